// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is the shift stage of a 32-bit integer datapath. It moves a data word left or right by 0 to 31 bit positions. Five operations are available: three plain shifts and two rotates. The plain shifts are a zero-filling left shift, a zero-filling right shift and a sign-filling right shift. In a rotate, the bits that leave one end come back in at the other end. The result is registered, so it appears one clock after the operands are presented.

The amount comes from one of two places. It is either a 5-bit amount taken from the instruction word, or the low 5 bits of a 32-bit register operand, and a select bit picks between them. The amount source that is not selected has no effect on the result. Operation codes that the unit does not recognise pass the data word through unchanged.

Top module: `shift_rotate_unit`

## Requirements
- R1: The result register takes its new value on the rising clock edge at which the operands are sampled. The result seen after edge N reflects the inputs held before edge N.
- R2: When `amt_from_reg` is 0, the amount is `imm_amt`, and `reg_amt` has no effect.
- R3: When `amt_from_reg` is 1, the amount is `reg_amt[4:0]`. Bits 31:5 of `reg_amt` and the whole of `imm_amt` have no effect.
- R4: Operation code 3'b000 shifts left and fills the freed low-order positions with 0.
- R5: Operation code 3'b001 shifts right and fills the freed high-order positions with 0.
- R6: Operation code 3'b010 shifts right and fills the freed high-order positions with copies of bit 31 of the input. An amount of 31 on a negative input gives 0xFFFFFFFF.
- R7: Operation code 3'b011 rotates left with no bit lost. For example, 0xD2345678 rotated left by 4 gives 0x2345678D.
- R8: Operation code 3'b100 rotates right with no bit lost. For example, 0xD2345678 rotated right by 4 gives 0x8D234567.
- R9: An amount of 0 returns the input word unchanged for every operation code.
- R10: The operation codes 3'b101, 3'b110 and 3'b111 return the input word unchanged, whatever the amount.
- R11: A synchronous active-high `rst` clears the result to 0 on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_val | input | 32 | Data word to shift or rotate |
| imm_amt | input | 5 | Amount field taken from the instruction |
| reg_amt | input | 32 | Register operand; its low 5 bits supply the amount |
| amt_from_reg | input | 1 | 1 selects the register amount, 0 selects the immediate amount |
| op | input | 3 | Operation code |
| result | output | 32 | Registered result |

## Verification
A wrong value at any one stage of the shifter shows up in the result one clock after the operands are applied. Only amounts that have that stage's bit set expose it, so the bench sweeps many amounts, including the extremes 0 and 31. A wrong fill or direction choice can look right on inputs with symmetric bit patterns. For that reason the bench uses words with a set top bit, words with a clear top bit, and a distinctive rotate pattern. A faulty amount select only shows when the two amount sources differ, so the bench always drives them with different values.

// File: rtl/shift_pkg.sv
package shift_pkg;

    // Operation codes; the values are part of the block's contract.
    typedef enum logic [2:0] {
        OP_SLL = 3'b000,
        OP_SRL = 3'b001,
        OP_SRA = 3'b010,
        OP_ROL = 3'b011,
        OP_ROR = 3'b100
    } shift_op_e;

    // What enters at the top of the right-moving core.
    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    typedef struct packed {
        logic  active;   // a recognised operation
        logic  mirror;   // left operations run reversed through the right core
        fill_e fill;
    } core_ctrl_t;

    function automatic core_ctrl_t decode_op(input logic [2:0] code);
        core_ctrl_t c;
        c = '{active: 1'b0, mirror: 1'b0, fill: FILL_ZERO};
        case (code)
            OP_SLL: c = '{active: 1'b1, mirror: 1'b1, fill: FILL_ZERO};
            OP_SRL: c = '{active: 1'b1, mirror: 1'b0, fill: FILL_ZERO};
            OP_SRA: c = '{active: 1'b1, mirror: 1'b0, fill: FILL_SIGN};
            OP_ROL: c = '{active: 1'b1, mirror: 1'b1, fill: FILL_WRAP};
            OP_ROR: c = '{active: 1'b1, mirror: 1'b0, fill: FILL_WRAP};
            default: c = '{active: 1'b0, mirror: 1'b0, fill: FILL_ZERO};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic [AW-1:0] imm_amt,
    input  logic [W-1:0]  reg_amt,
    input  logic          from_reg,
    output logic [AW-1:0] amt
);
    // Only the low AW bits of the register operand count.
    assign amt = from_reg ? reg_amt[AW-1:0] : imm_amt;
endmodule

// File: rtl/shift_bit_rev.sv
module shift_bit_rev #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign q[i] = en ? d[W-1-i] : d[i];
    end
endmodule

// File: rtl/shift_right_core.sv
module shift_right_core
    import shift_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic [W-1:0]  d,
    input  logic [AW-1:0] amt,
    input  fill_e         fill,
    output logic [W-1:0]  q
);
    logic [AW:0][W-1:0] stg;
    logic               sign_bit;

    assign sign_bit = d[W-1];
    assign stg[0]   = d;

    // One stage per amount bit; stage k moves by 2**k positions.
    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [S-1:0] incoming;

        always_comb begin
            case (fill)
                FILL_WRAP: incoming = stg[k][S-1:0];
                FILL_SIGN: incoming = {S{sign_bit}};
                default:   incoming = '0;
            endcase
        end

        assign stg[k+1] = amt[k] ? {incoming, stg[k][W-1:S]} : stg[k];
    end

    assign q = stg[AW];
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import shift_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  src_val,
    input  logic [AW-1:0] imm_amt,
    input  logic [W-1:0]  reg_amt,
    input  logic          amt_from_reg,
    input  logic [2:0]    op,
    output logic [W-1:0]  result
);
    core_ctrl_t    ctrl;
    logic [AW-1:0] amt;
    logic [W-1:0]  core_in;
    logic [W-1:0]  core_out;
    logic [W-1:0]  shaped;
    logic [W-1:0]  next_val;

    assign ctrl = decode_op(op);

    shift_amt_sel #(.W(W), .AW(AW)) u_amt (
        .imm_amt  (imm_amt),
        .reg_amt  (reg_amt),
        .from_reg (amt_from_reg),
        .amt      (amt)
    );

    shift_bit_rev #(.W(W)) u_rev_in (
        .en (ctrl.mirror),
        .d  (src_val),
        .q  (core_in)
    );

    shift_right_core #(.W(W), .AW(AW)) u_core (
        .d    (core_in),
        .amt  (amt),
        .fill (ctrl.fill),
        .q    (core_out)
    );

    shift_bit_rev #(.W(W)) u_rev_out (
        .en (ctrl.mirror),
        .d  (core_out),
        .q  (shaped)
    );

    assign next_val = ctrl.active ? shaped : src_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else begin
            result <= next_val;
        end
    end
endmodule

// File: rtl/shift_rotate_chk.sv
module shift_rotate_chk #(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  src_val,
    input logic [AW-1:0] imm_amt,
    input logic [W-1:0]  reg_amt,
    input logic          amt_from_reg,
    input logic [2:0]    op,
    input logic [W-1:0]  result
);
    logic [AW-1:0] eff_amt;
    assign eff_amt = amt_from_reg ? reg_amt[AW-1:0] : imm_amt;

    // R11
    reset_clear_chk: assert property (@(posedge clk) rst |=> result == '0);

    // R9
    zero_amt_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_amt == '0) |=> result == $past(src_val));

    // R10
    bad_code_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op > 3'b100) |=> result == $past(src_val));

    // R4
    left_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b000 && eff_amt != '0) |=> result[0] == 1'b0);

    // R5
    right_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b001 && eff_amt != '0) |=> result[W-1] == 1'b0);

    // R6
    sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b010) |=> result[W-1] == $past(src_val[W-1]));

    // R7
    rol_keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b011) |=> $countones(result) == $countones($past(src_val)));

    // R8
    ror_keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b100) |=> $countones(result) == $countones($past(src_val)));
endmodule

bind shift_rotate_unit shift_rotate_chk #(.W(W)) u_chk (.*);

// File: tb/sim_shift_rotate_unit.sv
module sim_shift_rotate_unit;
    localparam int W  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  src_val = '0;
    logic [AW-1:0] imm_amt = '0;
    logic [W-1:0]  reg_amt = '0;
    logic          amt_from_reg = 1'b0;
    logic [2:0]    op = '0;
    logic [W-1:0]  result;

    always #10 clk = ~clk;   // 50 MHz

    shift_rotate_unit #(.W(W)) u0 (
        .clk(clk), .rst(rst), .src_val(src_val), .imm_amt(imm_amt),
        .reg_amt(reg_amt), .amt_from_reg(amt_from_reg), .op(op),
        .result(result)
    );

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    function automatic logic [W-1:0] model(input logic [2:0] code,
                                           input logic [W-1:0] v, input int a);
        logic [W-1:0] r;
        r = v;
        case (code)
            3'd0: r = v << a;
            3'd1: r = v >> a;
            3'd2: r = $signed(v) >>> a;
            3'd3: for (int i = 0; i < W; i++) r[(i + a) % W] = v[i];
            3'd4: for (int i = 0; i < W; i++) r[i] = v[(i + a) % W];
            default: r = v;
        endcase
        return r;
    endfunction

    task automatic check_now(input logic [W-1:0] exp, input string tag);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s: result=%h expected=%h", tag, result, exp);
        end
    endtask

    // Driver: apply operands at a falling edge and queue the expected value.
    task automatic drive(input logic [2:0] code, input logic [W-1:0] v,
                         input logic [AW-1:0] imm, input logic [W-1:0] regv,
                         input logic from_reg, input string tag);
        int    a;
        item_t it;
        @(negedge clk);
        op = code; src_val = v; imm_amt = imm; reg_amt = regv;
        amt_from_reg = from_reg;
        a = from_reg ? int'(regv[AW-1:0]) : int'(imm);
        it.exp = model(code, v, a);
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare just after the edge that loads the result (R1).
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sbq.size() > 0) begin
                it = sbq.pop_front();
                check_now(it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: result=%h expected=completion", result);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now('0, "R11 reset state");
        rst = 1'b0;

        drive(3'b000, 32'h1234_5678, 5'd4,  32'h0000_0011, 1'b0, "R4 R1 left 4");
        drive(3'b000, 32'hFFFF_FFFF, 5'd31, 32'h0,         1'b0, "R4 left 31");
        drive(3'b001, 32'hF000_0000, 5'd5,  32'h0000_0002, 1'b0, "R5 right 5");
        drive(3'b001, 32'hFFFF_FFFF, 5'd31, 32'h0,         1'b0, "R5 right 31");
        drive(3'b010, 32'h8000_1234, 5'd8,  32'h0,         1'b0, "R6 arith negative");
        drive(3'b010, 32'h7000_1234, 5'd8,  32'h0,         1'b0, "R6 arith positive");
        drive(3'b010, 32'h8000_0000, 5'd31, 32'h0,         1'b0, "R6 arith 31");
        drive(3'b011, 32'hD234_5678, 5'd4,  32'h0,         1'b0, "R7 rotate left 4");
        drive(3'b011, 32'h8000_0001, 5'd31, 32'h0,         1'b0, "R7 rotate left 31");
        drive(3'b100, 32'hD234_5678, 5'd4,  32'h0,         1'b0, "R8 rotate right 4");
        drive(3'b100, 32'h0000_0003, 5'd1,  32'h0,         1'b0, "R8 rotate right 1");
        for (int c = 0; c < 5; c++)
            drive(3'(c), 32'hA5C3_0F96, 5'd0, 32'h0000_0007, 1'b0, "R9 zero amount");
        drive(3'b011, 32'hA5C3_0F96, 5'd17, 32'hFFFF_FFE0, 1'b1, "R9 R3 zero reg amount");
        drive(3'b000, 32'h0000_0001, 5'd17, 32'hFFFF_FFE3, 1'b1, "R3 reg amount");
        drive(3'b100, 32'h0000_00F0, 5'd2,  32'h1234_5A64, 1'b1, "R3 reg rotate");
        drive(3'b001, 32'h8000_0000, 5'd2,  32'hFFFF_FFFF, 1'b0, "R2 immediate amount");
        drive(3'b010, 32'h8000_0000, 5'd9,  32'h0000_0003, 1'b0, "R2 immediate arith");
        for (int c = 5; c < 8; c++)
            drive(3'(c), 32'h1357_9BDF, 5'd13, 32'h0000_0009, 1'b0, "R10 unused code");
        drive(3'b111, 32'h2468_ACE0, 5'd3, 32'h0000_0005, 1'b1, "R10 unused code reg");

        for (int n = 0; n < 80; n++)
            drive(3'($urandom % 8), $urandom, 5'($urandom), $urandom,
                  1'($urandom), "R4 R5 R6 R7 R8 mixed");

        // Mid-run reset
        @(negedge clk);
        src_val = 32'hFFFF_FFFF; op = 3'b111;
        while (sbq.size() > 0) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_now('0, "R11 reset mid-run");
        rst = 1'b0;
        drive(3'b011, 32'hD234_5678, 5'd4, 32'h0, 1'b0, "R7 after reset");

        @(negedge clk);
        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule